// File: doc/BRIEF.md
# Wide-Word Dual-Clock FIFO Built from Parallel Slices

This block makes one wide first-in first-out buffer out of several narrower dual-clock FIFO slices placed side by side. Every slice shares the write clock, the write enable, the read clock and the read enable. Each slice stores one field of the wide input word. The output word is the slices' outputs joined back together in the same field order. Slices share one depth, and each slice may have its own width.

Each slice passes pointers between the clock domains in Gray code through its own synchronizer chain. Because of this, two slices can change their full, empty or ready state on different cycles. The wrapper merges the per-slice flags with gating that depends on the mode. The merged write flag allows a write only when every slice has room. The merged read flag allows a read only when every slice holds the word. All slices therefore stay at the same fill level, and no word is ever split across slices.

A parameter selects one of two modes. In standard mode a read loads the output register. In first-word-fall-through mode the head word appears at the output without a read. The half-full, near-full and near-empty indications come from the first slice only.

Top module: `wfx_wide`

## Requirements
- R1: Slice i stores the bits of the data word starting at the sum of the widths of slices 0 to i-1. The default layout is slice 0 on bits 7:0 and slice 1 on bits 17:8. The read data is the stored words joined in the same layout and returned in write order, with no word mixing fields from different writes.
- R2: While both resets are held and after reset, the buffer is empty. In standard mode rd_flag is 0 and wr_flag is 1. In fall-through mode rd_flag is 1 and wr_flag is 0. half_full and near_full are 0, near_empty is 1, and rd_data is 0.
- R3: In standard mode, rd_flag is the active-low empty indication merged by AND over the slices: 1 only when every slice holds a word. After a write into an empty buffer, rd_flag rises only once the slowest slice has synchronized. If one slice has one extra synchronizer stage, that is the 3rd read-clock rising edge after the write edge.
- R4: In standard mode, wr_flag is the active-low full indication merged by AND over the slices. It goes to 0 at the write-clock edge that accepts the DEPTH-th unread word, and it is 1 while any space remains.
- R5: A write presented while the merged write flag blocks writes (wr_flag 0 in standard mode, 1 in fall-through mode) is ignored and stores nothing in any slice.
- R6: A read presented while the merged read flag shows no data (rd_flag 0 in standard mode, 1 in fall-through mode) is ignored. rd_data keeps its value and no slice advances.
- R7: In standard mode, rd_data takes the head word at the read-clock edge that accepts the read, and it holds between accepted reads.
- R8: In fall-through mode, rd_flag is the active-low output-ready indication merged by OR over the slices: 0 only when every slice presents the head word. The head word shows on rd_data without a read, and a read pops it. With synchronizer depths of 3 and 2 stages, rd_flag falls at the 4th read-clock edge after a write into an empty buffer.
- R9: In fall-through mode, wr_flag is the active-low input-ready indication merged by OR over the slices. Writes are accepted only while it is 0. A concurrent stream of writes and reads returns every word once, in order.
- R10: half_full, near_full and near_empty come from slice 0 only. half_full is 1 when its stored count exceeds DEPTH/2. near_full is 1 when the count is at least DEPTH-AF_GAP. near_empty (read domain) is 1 when the count is at most AE_GAP. Defaults: DEPTH 16, AF_GAP 2, AE_GAP 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock, shared by all slices |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Wide write word |
| wr_flag | output | 1 | Merged write flag (full or input-ready, active low) |
| half_full | output | 1 | Slice 0 holds more than DEPTH/2 words |
| near_full | output | 1 | Slice 0 holds at least DEPTH-AF_GAP words |
| rd_clk | input | 1 | Read clock, shared by all slices |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Wide read word |
| rd_flag | output | 1 | Merged read flag (empty or output-ready, active low) |
| near_empty | output | 1 | Slice 0 holds at most AE_GAP words |

## Verification
Results inside one clock domain fall due exactly one edge after the stimulus. The bench drives on the falling edge of the owning clock and samples at the next falling edge. This applies to rd_data after an accepted standard read, wr_flag after the filling write, the write-side level flags, and near_empty after each pop. Cross-domain results have fixed edge counts, because the two clock periods never share a rising edge. The first flag release after a write is counted as read-clock rising edges since the write edge: exactly 3 in standard mode and exactly 4 in fall-through mode with the skewed slice. Waits that only need the buffer to settle poll at falling edges under a bounded count.

// File: rtl/wfx_pkg.sv
package wfx_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    // per-slice flags in the active-low form the merge stage consumes
    typedef struct packed {
        logic wr_n;
        logic rd_n;
    } slice_flag_t;

    // level indications; only a tap slice drives non-zero values
    typedef struct packed {
        logic half;
        logic near_full;
        logic near_empty;
    } level_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int k = 30; k >= 0; k--) begin
            b[k] = b[k+1] ^ g[k];
        end
        return b;
    endfunction

endpackage

// File: rtl/wfx_sync.sv
module wfx_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= '0;
        end else begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wfx_slice.sv
module wfx_slice
    import wfx_pkg::*;
#(
    parameter int         W      = 8,
    parameter int         DEPTH  = 16,
    parameter int         SKEW   = 0,
    parameter fifo_mode_e MODE   = MODE_STD,
    parameter bit         TAP    = 1'b0,
    parameter int         AF_GAP = 2,
    parameter int         AE_GAP = 2
) (
    input  logic         wclk,
    input  logic         wrst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         rclk,
    input  logic         rrst,
    input  logic         pop,
    output logic [W-1:0] dout,
    output slice_flag_t  flg,
    output level_t       lvl
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int SYNC_N = 2 + SKEW;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rg_s, wg_s;
    logic [PW-1:0] wnext, rnext;
    logic          full, empty, ovalid, load;

    // ---------------- write domain ----------------
    assign wnext = wbin + 1'b1;

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push) begin
            wbin  <= wnext;
            wgray <= PW'(to_gray(32'(wnext)));
        end
    end

    always_ff @(posedge wclk) begin
        if (push) mem[wbin[AW-1:0]] <= din;
    end

    wfx_sync #(.W(PW), .STAGES(SYNC_N)) u_rsync (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rg_s)
    );

    assign full = (wgray == {~rg_s[PW-1:PW-2], rg_s[PW-3:0]});

    // ---------------- read domain ----------------
    wfx_sync #(.W(PW), .STAGES(SYNC_N)) u_wsync (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wg_s)
    );

    assign empty = (rgray == wg_s);
    assign rnext = rbin + 1'b1;

    generate
        if (MODE == MODE_FWFT) begin : g_load_fwft
            assign load = !empty && (!ovalid || pop);
        end else begin : g_load_std
            assign load = pop;
        end
    endgenerate

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin   <= '0;
            rgray  <= '0;
            dout   <= '0;
            ovalid <= 1'b0;
        end else begin
            if (load) begin
                rbin  <= rnext;
                rgray <= PW'(to_gray(32'(rnext)));
                dout  <= mem[rbin[AW-1:0]];
            end
            if (MODE == MODE_FWFT) begin
                if (load)     ovalid <= 1'b1;
                else if (pop) ovalid <= 1'b0;
            end
        end
    end

    // ---------------- flags in mode form ----------------
    generate
        if (MODE == MODE_FWFT) begin : g_flag_fwft
            assign flg.wr_n = full;
            assign flg.rd_n = !ovalid;
        end else begin : g_flag_std
            assign flg.wr_n = !full;
            assign flg.rd_n = !empty;
        end
    endgenerate

    // ---------------- level indications ----------------
    generate
        if (TAP) begin : g_level
            logic [31:0]   rb_w, wb_r;
            logic [PW-1:0] wcount, rcount;
            assign rb_w   = from_gray(32'(rg_s));
            assign wb_r   = from_gray(32'(wg_s));
            assign wcount = wbin - rb_w[PW-1:0];
            assign rcount = wb_r[PW-1:0] - rbin;
            assign lvl.half       = (32'(wcount) >  32'(DEPTH / 2));
            assign lvl.near_full  = (32'(wcount) >= 32'(DEPTH - AF_GAP));
            assign lvl.near_empty = (32'(rcount) <= 32'(AE_GAP));
        end else begin : g_nolevel
            assign lvl = '0;
        end
    endgenerate

    // ---------------- assertions ----------------
    a_r5_no_overflow: assert property (@(posedge wclk) disable iff (wrst)
        push |-> !full)
        else $error("slice written while full");

    a_r6_no_underflow: assert property (@(posedge rclk) disable iff (rrst)
        pop |-> ((MODE == MODE_FWFT) ? ovalid : !empty))
        else $error("slice read without data");
endmodule

// File: rtl/wfx_merge.sv
module wfx_merge
    import wfx_pkg::*;
#(
    parameter int         N    = 2,
    parameter fifo_mode_e MODE = MODE_STD
) (
    input  logic [N-1:0] wr_n_v,
    input  logic [N-1:0] rd_n_v,
    input  logic [N-1:0] half_v,
    input  logic [N-1:0] nfull_v,
    input  logic [N-1:0] nempty_v,
    output logic         wflag,
    output logic         rflag,
    output level_t       lvl
);
    generate
        if (MODE == MODE_FWFT) begin : g_or
            // ready is low-active: any slice not ready keeps the whole word not ready
            assign wflag = |wr_n_v;
            assign rflag = |rd_n_v;
        end else begin : g_and
            // not-full / not-empty: any slice full or empty blocks the whole word
            assign wflag = &wr_n_v;
            assign rflag = &rd_n_v;
        end
    endgenerate

    // only the tap slice drives level bits, others hold zero
    assign lvl.half       = |half_v;
    assign lvl.near_full  = |nfull_v;
    assign lvl.near_empty = |nempty_v;
endmodule

// File: rtl/wfx_wide.sv
module wfx_wide
    import wfx_pkg::*;
#(
    parameter int         NSLICE          = 2,
    parameter int         SLICE_W [NSLICE] = '{8, 10},
    parameter int         SKEW    [NSLICE] = '{0, 0},
    parameter int         DATA_W          = 18,
    parameter int         DEPTH           = 16,
    parameter int         AF_GAP          = 2,
    parameter int         AE_GAP          = 2,
    parameter fifo_mode_e MODE            = MODE_STD
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_flag,
    output logic              half_full,
    output logic              near_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              near_empty
);
    function automatic int field_lo(input int idx);
        int s;
        s = 0;
        for (int k = 0; k < idx; k++) s += SLICE_W[k];
        return s;
    endfunction

    generate
        if (field_lo(NSLICE) != DATA_W) begin : g_width_mismatch
            $error("slice widths do not add up to DATA_W");
        end
    endgenerate

    logic [NSLICE-1:0] wr_n_v, rd_n_v, half_v, nfull_v, nempty_v;
    logic              wr_acc, rd_acc;
    level_t            lvl;

    // writes and reads go to every slice at once, gated by the merged flags
    assign wr_acc = wr_en && ((MODE == MODE_FWFT) ? !wr_flag : wr_flag);
    assign rd_acc = rd_en && ((MODE == MODE_FWFT) ? !rd_flag : rd_flag);

    generate
        for (genvar i = 0; i < NSLICE; i++) begin : g_slice
            localparam int LO = field_lo(i);
            localparam int W  = SLICE_W[i];
            slice_flag_t flg;
            level_t      sl;

            wfx_slice #(
                .W(W), .DEPTH(DEPTH), .SKEW(SKEW[i]), .MODE(MODE),
                .TAP(i == 0), .AF_GAP(AF_GAP), .AE_GAP(AE_GAP)
            ) u_slice (
                .wclk(wr_clk), .wrst(wr_rst), .push(wr_acc),
                .din(wr_data[LO +: W]),
                .rclk(rd_clk), .rrst(rd_rst), .pop(rd_acc),
                .dout(rd_data[LO +: W]),
                .flg(flg), .lvl(sl)
            );

            assign wr_n_v[i]   = flg.wr_n;
            assign rd_n_v[i]   = flg.rd_n;
            assign half_v[i]   = sl.half;
            assign nfull_v[i]  = sl.near_full;
            assign nempty_v[i] = sl.near_empty;
        end
    endgenerate

    wfx_merge #(.N(NSLICE), .MODE(MODE)) u_merge (
        .wr_n_v(wr_n_v), .rd_n_v(rd_n_v),
        .half_v(half_v), .nfull_v(nfull_v), .nempty_v(nempty_v),
        .wflag(wr_flag), .rflag(rd_flag), .lvl(lvl)
    );

    assign half_full  = lvl.half;
    assign near_full  = lvl.near_full;
    assign near_empty = lvl.near_empty;

    // ---------------- assertions ----------------
    logic wr_blocked, rd_has;
    assign wr_blocked = (MODE == MODE_FWFT) ? wr_flag : !wr_flag;
    assign rd_has     = (MODE == MODE_FWFT) ? !rd_flag : rd_flag;

    a_r4_block_after_write: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $rose(wr_blocked) |-> $past(wr_acc))
        else $error("write side blocked without a write");

    a_r3_drain_after_read: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $fell(rd_has) |-> $past(rd_acc))
        else $error("read side lost data without a read");

    generate
        if (MODE == MODE_FWFT) begin : g_chk_fwft
            a_r8_head_hold: assert property (@(posedge rd_clk) disable iff (rd_rst)
                (!rd_flag && !rd_en) |=> ($stable(rd_data) && !rd_flag))
                else $error("presented head word changed without a pop");
        end else begin : g_chk_std
            a_r7_hold_std: assert property (@(posedge rd_clk) disable iff (rd_rst)
                !rd_acc |=> $stable(rd_data))
                else $error("read data changed without an accepted read");
        end
    endgenerate
endmodule

// File: tb/wfx_wide_test.sv
`timescale 1ns/100ps
module wfx_wide_test;
    import wfx_pkg::*;

    localparam int DW    = 18;
    localparam int DEPTH = 16;

    int checks = 0;
    int errors = 0;

    logic wclk = 1'b0;
    logic rclk = 1'b0;
    always #2   wclk = ~wclk;   // 250 MHz
    always #3.3 rclk = ~rclk;   // unrelated read clock

    int rcnt = 0;
    always @(posedge rclk) rcnt <= rcnt + 1;

    logic wrst = 1'b1, rrst = 1'b1;

    // standard-mode instance, slice 1 one synchronizer stage slower
    logic          s_we = 0, s_re = 0;
    logic [DW-1:0] s_wdata = '0, s_rdata;
    logic          s_wflag, s_rflag, s_hf, s_af, s_ae;

    wfx_wide #(.SKEW('{0, 1}), .MODE(MODE_STD)) uut (
        .wr_clk(wclk), .wr_rst(wrst), .wr_en(s_we), .wr_data(s_wdata),
        .wr_flag(s_wflag), .half_full(s_hf), .near_full(s_af),
        .rd_clk(rclk), .rd_rst(rrst), .rd_en(s_re), .rd_data(s_rdata),
        .rd_flag(s_rflag), .near_empty(s_ae)
    );

    // fall-through instance, slice 0 one synchronizer stage slower
    logic          f_we = 0, f_re = 0;
    logic [DW-1:0] f_wdata = '0, f_rdata;
    logic          f_wflag, f_rflag, f_hf, f_af, f_ae;

    wfx_wide #(.SKEW('{1, 0}), .MODE(MODE_FWFT)) uut_fwft (
        .wr_clk(wclk), .wr_rst(wrst), .wr_en(f_we), .wr_data(f_wdata),
        .wr_flag(f_wflag), .half_full(f_hf), .near_full(f_af),
        .rd_clk(rclk), .rd_rst(rrst), .rd_en(f_re), .rd_data(f_rdata),
        .rd_flag(f_rflag), .near_empty(f_ae)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 18'h2D1) ^ 18'h15A5A;
    endfunction

    int rc_at_write = 0;

    task automatic push_s(input logic [DW-1:0] d, output bit took);
        @(negedge wclk);
        took = s_wflag;
        s_we = 1'b1; s_wdata = d;
        @(posedge wclk);
        rc_at_write = rcnt;
        @(negedge wclk);
        s_we = 1'b0;
    endtask

    task automatic pop_s(output logic [DW-1:0] d, output bit took);
        @(negedge rclk);
        took = s_rflag;
        s_re = 1'b1;
        @(negedge rclk);
        s_re = 1'b0;
        d = s_rdata;
    endtask

    task automatic push_f(input logic [DW-1:0] d);
        @(negedge wclk);
        f_we = 1'b1; f_wdata = d;
        while (f_wflag) @(negedge wclk);
        @(posedge wclk);
        rc_at_write = rcnt;
        @(negedge wclk);
        f_we = 1'b0;
    endtask

    task automatic pop_f(output logic [DW-1:0] d, output bit took);
        @(negedge rclk);
        took = !f_rflag;
        d = f_rdata;
        f_re = 1'b1;
        @(negedge rclk);
        f_re = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge rclk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(s_rflag == 1'b0, "R2 std rd_flag", 32'(s_rflag), 0);
        chk(s_wflag == 1'b1, "R2 std wr_flag", 32'(s_wflag), 1);
        chk(f_rflag == 1'b1, "R2 fwft rd_flag", 32'(f_rflag), 1);
        chk(f_wflag == 1'b0, "R2 fwft wr_flag", 32'(f_wflag), 0);
        chk({s_hf, s_af, s_ae} == 3'b001, "R2 level flags", 32'({s_hf, s_af, s_ae}), 1);
        chk(s_rdata == '0, "R2 rd_data", 32'(s_rdata), 0);
    endtask

    task automatic t_skew_latency();
        bit took;
        logic [DW-1:0] d;
        int lat;
        push_s(18'h2AA55, took);
        while (!s_rflag) @(negedge rclk);
        lat = rcnt - rc_at_write;
        chk(lat == 3, "R3 merged empty release edge", 32'(lat), 3);
        pop_s(d, took);
        chk(took && d == 18'h2AA55, "R7 std read data", 32'(d), 32'h2AA55);
        chk(s_rflag == 1'b0, "R3 empty after last read", 32'(s_rflag), 0);
    endtask

    task automatic t_order();
        bit took;
        logic [DW-1:0] d;
        logic [DW-1:0] words [5] = '{18'h3FF00, 18'h000FF, 18'h15A5A, 18'h2A5A5, 18'h00001};
        foreach (words[i]) push_s(words[i], took);
        settle(6);
        foreach (words[i]) begin
            pop_s(d, took);
            chk(took && d == words[i], "R1 field layout and order", 32'(d), 32'(words[i]));
        end
    endtask

    task automatic t_underflow();
        bit took;
        logic [DW-1:0] last, d;
        settle(6);
        last = s_rdata;
        pop_s(d, took);
        chk(!took, "R6 read refused when empty", 32'(took), 0);
        chk(d == last, "R6 rd_data held", 32'(d), 32'(last));
        chk(s_rflag == 1'b0, "R6 still empty", 32'(s_rflag), 0);
    endtask

    task automatic t_full();
        bit took;
        logic [DW-1:0] d;
        for (int n = 1; n <= DEPTH; n++) begin
            push_s(pat(n), took);
            chk(took, "R4 space before full", 32'(took), 1);
            chk(s_hf == (n > DEPTH / 2), "R10 half_full", 32'(s_hf), 32'(n > DEPTH / 2));
            chk(s_af == (n >= DEPTH - 2), "R10 near_full", 32'(s_af), 32'(n >= DEPTH - 2));
            if (n < DEPTH) chk(s_wflag == 1'b1, "R4 not full yet", 32'(s_wflag), 1);
        end
        chk(s_wflag == 1'b0, "R4 full after DEPTH writes", 32'(s_wflag), 0);
        push_s(18'h3FFFF, took);                       // R5: must be dropped
        chk(!took, "R5 write refused when full", 32'(took), 0);
        settle(8);
        chk(s_ae == 1'b0, "R10 near_empty clear when full", 32'(s_ae), 0);
        for (int n = 1; n <= DEPTH; n++) begin
            pop_s(d, took);
            chk(took && d == pat(n), "R5 stored sequence intact", 32'(d), 32'(pat(n)));
            chk(s_ae == (DEPTH - n <= 2), "R10 near_empty", 32'(s_ae), 32'(DEPTH - n <= 2));
        end
        settle(8);
        chk(s_rflag == 1'b0, "R5 dropped word absent", 32'(s_rflag), 0);
    endtask

    task automatic t_fwft_single();
        bit took;
        logic [DW-1:0] d;
        int lat;
        push_f(18'h1C3E7);
        while (f_rflag) @(negedge rclk);
        lat = rcnt - rc_at_write;
        chk(lat == 4, "R8 ready edge count", 32'(lat), 4);
        chk(f_rdata == 18'h1C3E7, "R8 head shown without read", 32'(f_rdata), 32'h1C3E7);
        pop_f(d, took);
        chk(took && d == 18'h1C3E7, "R8 popped word", 32'(d), 32'h1C3E7);
        chk(f_rflag == 1'b1, "R8 not ready after pop", 32'(f_rflag), 1);
        pop_f(d, took);
        chk(!took, "R6 fwft read refused when empty", 32'(took), 0);
    endtask

    task automatic t_fwft_fill();
        bit took;
        logic [DW-1:0] d;
        int acc;
        acc = 0;
        for (int n = 0; n < DEPTH + 4; n++) begin
            @(negedge wclk);
            if (!f_wflag) begin
                f_we = 1'b1; f_wdata = pat(100 + acc);
                @(negedge wclk);
                f_we = 1'b0;
                acc++;
            end else begin
                f_we = 1'b1; f_wdata = 18'h3FFFF;      // R5: refused
                @(negedge wclk);
                f_we = 1'b0;
            end
            settle(2);
        end
        chk(f_wflag == 1'b1, "R9 input not ready when full", 32'(f_wflag), 1);
        chk(acc == DEPTH + 1, "R9 accepted count", 32'(acc), DEPTH + 1);
        for (int n = 0; n < acc; n++) begin
            while (f_rflag) @(negedge rclk);
            pop_f(d, took);
            chk(took && d == pat(100 + n), "R9 fill order", 32'(d), 32'(pat(100 + n)));
        end
        settle(8);
        chk(f_rflag == 1'b1, "R5 fwft refused words absent", 32'(f_rflag), 1);
    endtask

    task automatic t_fwft_stream();
        int bad;
        bad = 0;
        fork
            begin
                for (int i = 0; i < 40; i++) push_f(pat(300 + i));
            end
            begin
                int got;
                bit took;
                logic [DW-1:0] d;
                got = 0;
                while (got < 40) begin
                    pop_f(d, took);
                    if (took) begin
                        if (d != pat(300 + got)) bad++;
                        got++;
                    end
                end
            end
        join
        chk(bad == 0, "R9 stream order", 32'(bad), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (10) @(negedge wclk);
        t_reset();
        wrst = 1'b0;
        @(negedge rclk);
        rrst = 1'b0;
        settle(4);
        t_reset();
        t_skew_latency();
        t_order();
        t_underflow();
        t_full();
        t_fwft_single();
        t_fwft_fill();
        t_fwft_stream();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule